// File: doc/BRIEF.md
# Two-Wire Word Register Slave

This block is the bus-facing front end of a bank of 16-bit registers on a two-wire serial bus (I2C/SMBus style). It only ever responds: the master sources the clock in both directions, and the block never drives the clock line. The block oversamples the clock and data lines with the system clock and finds START, STOP and both clock edges. It acknowledges a device address of the form `1` + six strapped bits + R/W. It then takes a command byte, which selects the register, and moves exactly two data bytes per access, high byte first. Data is pulled low through an open-drain enable.

A write is START, address (R/W=0), command, high byte, low byte, STOP. Each of the four bytes is acknowledged. The word is committed to the register file once the low byte's acknowledge clock is over. A read is an address (R/W=0) and command, then a repeated START with the address at R/W=1. The block then returns the selected word, high byte first, and goes on to the low byte only if the master acknowledged the high one. For a fixed time after reset the block ignores every START, and a STOP always puts it back to standby.

Top module: `smb_word_slave`

## Requirements
- R1: Coming out of reset, `sda_oe` and `rf_we` are low.
- R2: For `LOCK_CYC` system clocks after reset is released, a START is ignored: a matching address byte then gets no acknowledge and `sda_oe` stays low.
- R3: Only an address byte equal to {1, `dev_id[5:0]`, R/W}, bit 7 first, is acknowledged (SDA low on the ninth clock). Any other address byte is not acknowledged, and the block then waits for the next START.
- R4: A complete write (address with R/W=0, command, high byte, low byte) gets four acknowledges. It then causes exactly one single-cycle `rf_we` pulse with `rf_addr` equal to the command byte and `rf_wdata` = {high, low}.
- R5: A STOP or a repeated START that arrives before the low data byte has been acknowledged discards the partial word. The register file is not written.
- R6: A third data byte after a complete write is not acknowledged and does not write again.
- R7: In a read, the block shifts out bit 15 of the word at `rf_addr` = command first, high byte then low byte. It releases SDA for every 1 bit.
- R8: If the master does not acknowledge the high byte, the block releases SDA and drives no low byte.
- R9: `sda_oe` changes only while the synchronized SCL is low.
- R10: After a STOP, SDA is released, and clocking a matching address byte without a new START gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| dev_id | input | 6 | Strapped six low bits of the device address |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| rf_addr | output | 8 | Register index (last command byte) |
| rf_we | output | 1 | One-cycle write strobe to the register file |
| rf_wdata | output | 16 | Word to write |
| rf_re | output | 1 | One-cycle strobe when the read word is captured |
| rf_rdata | input | 16 | Word at `rf_addr`, combinational from the register file |

## Verification
Two functions can fall in the same cycle: the end of the power-up lockout and the detection of a START. A START counts only if the lockout has already finished in the cycle the START is seen. The bench issues a START immediately after reset, so the whole address byte runs across the end of the lockout. It judges the case by the missing acknowledge, then repeats the access well after the lockout and expects every byte to be acknowledged.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ID_W   = 6;

  typedef enum logic [2:0] {
    ST_IDLE,   // standby, waits for START
    ST_RX,     // shifting a byte in from the master
    ST_ACK,    // slave holds SDA low for the ninth clock
    ST_TX,     // shifting a data byte out to the master
    ST_MACK    // master's acknowledge slot after a sent byte
  } smb_state_t;

  // Byte position within a transfer, counted from the address byte.
  typedef enum logic [1:0] {
    POS_ADDR,
    POS_CMD,
    POS_HI,
    POS_LO
  } smb_pos_t;

  // Address byte matches when bit 7 is 1 and bits 6..1 equal the strap.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ID_W-1:0]   id);
    return (b[BYTE_W-1] == 1'b1) && (b[BYTE_W-2:1] == id);
  endfunction

  // Upper byte of a word as sent first on the wire.
  function automatic logic [BYTE_W-1:0] hi_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lo_of(input logic [WORD_W-1:0] w);
    return w[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic scl_p;
  logic sda_p;

  // Idle bus reads high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_ff[SYNC_STAGES-1];
      sda_p  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_ff[SYNC_STAGES-1];
  assign sda_s    = sda_ff[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // Data edges count as conditions only while the clock stays high.
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_lockout.sv
module smb_lockout #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic lock_done
);

  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lock_done = (cnt == LIMIT);

endmodule

// File: rtl/smb_word_fsm.sv
module smb_word_fsm
  import smb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_done,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_ev,
  input  logic                stop_ev,
  input  logic [ID_W-1:0]     dev_id,
  input  logic [WORD_W-1:0]   rf_rdata,
  output logic                sda_oe,
  output logic [BYTE_W-1:0]   rf_addr,
  output logic                rf_we,
  output logic [WORD_W-1:0]   rf_wdata,
  output logic                rf_re,
  output logic                busy
);

  localparam logic [3:0] BITS = 4'(BYTE_W);

  smb_state_t        state;
  smb_pos_t          pos;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [3:0]        bit_cnt;
  logic              rd_mode;
  logic              seen_rise;
  logic              m_ack;
  logic              hi_phase;
  logic [BYTE_W-1:0] cmd_q;
  logic [BYTE_W-1:0] wd_hi;
  logic [BYTE_W-1:0] wd_lo;
  logic [WORD_W-1:0] rd_word;

  // Named decision wires.
  logic byte_in_done;
  logic ack_clk_over;
  logic id_match;
  logic start_ok;

  assign byte_in_done = scl_fall && (bit_cnt == BITS);
  assign ack_clk_over = scl_fall && seen_rise;
  assign id_match     = addr_hit(rx_sh, dev_id);
  assign start_ok     = start_ev && lock_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pos       <= POS_ADDR;
      rx_sh     <= '0;
      tx_sh     <= '0;
      bit_cnt   <= '0;
      rd_mode   <= 1'b0;
      seen_rise <= 1'b0;
      m_ack     <= 1'b0;
      hi_phase  <= 1'b0;
      cmd_q     <= '0;
      wd_hi     <= '0;
      wd_lo     <= '0;
      rd_word   <= '0;
      sda_oe    <= 1'b0;
      rf_we     <= 1'b0;
      rf_re     <= 1'b0;
      rf_wdata  <= '0;
    end else begin
      rf_we <= 1'b0;
      rf_re <= 1'b0;
      if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ok) begin
        // Fresh or repeated START: any partial word is dropped.
        state   <= ST_RX;
        pos     <= POS_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            sda_oe <= 1'b0;
          end

          ST_RX: begin
            if (scl_rise && bit_cnt != BITS) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_in_done) begin
              seen_rise <= 1'b0;
              unique case (pos)
                POS_ADDR: begin
                  if (id_match) begin
                    rd_mode <= rx_sh[0];
                    sda_oe  <= 1'b1;
                    state   <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                POS_CMD: begin
                  cmd_q  <= rx_sh;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                POS_HI: begin
                  wd_hi  <= rx_sh;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                POS_LO: begin
                  wd_lo  <= rx_sh;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
              endcase
            end
          end

          ST_ACK: begin
            if (scl_rise) begin
              seen_rise <= 1'b1;
            end
            if (ack_clk_over) begin
              sda_oe <= 1'b0;
              if (pos == POS_ADDR && rd_mode) begin
                // Capture the whole word once so both bytes agree.
                rd_word  <= rf_rdata;
                rf_re    <= 1'b1;
                hi_phase <= 1'b1;
                sda_oe   <= ~rf_rdata[WORD_W-1];
                tx_sh    <= {hi_of(rf_rdata)[BYTE_W-2:0], 1'b0};
                bit_cnt  <= 4'd1;
                state    <= ST_TX;
              end else if (pos == POS_LO) begin
                rf_we    <= 1'b1;
                rf_wdata <= {wd_hi, wd_lo};
                state    <= ST_IDLE;
              end else begin
                pos     <= smb_pos_t'(pos + 2'd1);
                bit_cnt <= '0;
                state   <= ST_RX;
              end
            end
          end

          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt != BITS) begin
                sda_oe  <= ~tx_sh[BYTE_W-1];
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end else begin
                sda_oe    <= 1'b0;
                seen_rise <= 1'b0;
                state     <= ST_MACK;
              end
            end
          end

          ST_MACK: begin
            if (scl_rise) begin
              seen_rise <= 1'b1;
              m_ack     <= ~sda_s;
            end
            if (ack_clk_over) begin
              if (m_ack && hi_phase) begin
                hi_phase <= 1'b0;
                sda_oe   <= ~rd_word[BYTE_W-1];
                tx_sh    <= {lo_of(rd_word)[BYTE_W-2:0], 1'b0};
                bit_cnt  <= 4'd1;
                state    <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end

          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign rf_addr = cmd_q;
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/smb_word_slave.sv
module smb_word_slave
  import smb_pkg::*;
#(
  parameter int LOCK_CYC    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [5:0]        dev_id,
  output logic              sda_oe,
  output logic [7:0]        rf_addr,
  output logic              rf_we,
  output logic [15:0]       rf_wdata,
  output logic              rf_re,
  input  logic [15:0]       rf_rdata
);

  // Internal events, named for the checker.
  logic scl_s;
  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic start_ev;
  logic stop_ev;
  logic lock_done;
  logic busy;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_done (lock_done)
  );

  smb_word_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_done (lock_done),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .dev_id    (dev_id),
    .rf_rdata  (rf_rdata),
    .sda_oe    (sda_oe),
    .rf_addr   (rf_addr),
    .rf_we     (rf_we),
    .rf_wdata  (rf_wdata),
    .rf_re     (rf_re),
    .busy      (busy)
  );

endmodule

// File: rtl/smb_word_slave_chk.sv
module smb_word_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_done,
  input logic start_ev,
  input logic stop_ev,
  input logic scl_fall,
  input logic scl_s,
  input logic sda_oe,
  input logic rf_we,
  input logic busy
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe && !rf_we));

  assert_lockout_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_done |-> !sda_oe);

  assert_early_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !lock_done) |=> !busy);

  assert_write_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_write_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(scl_fall));

  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  assert_stop_to_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!busy && !sda_oe));

endmodule

bind smb_word_slave smb_word_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock_done (lock_done),
  .start_ev  (start_ev),
  .stop_ev   (stop_ev),
  .scl_fall  (scl_fall),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .rf_we     (rf_we),
  .busy      (busy)
);

// File: tb/sim_smb_word_slave.sv
`timescale 1ns/1ps
module sim_smb_word_slave;

  localparam int Q = 8;                 // system clocks per quarter bus bit
  localparam logic [5:0] DEV = 6'h15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [7:0] rf_addr;
  logic rf_we;
  logic [15:0] rf_wdata;
  logic rf_re;
  logic [15:0] rf_rdata;
  logic sda_bus;

  logic [15:0] bank [0:15];
  logic [15:0] model [0:15];
  int wr_cnt = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign sda_bus  = m_sda & ~sda_oe;   // wired-AND bus
  assign rf_rdata = bank[rf_addr[3:0]];

  always @(posedge clk) begin
    if (rf_we) begin
      bank[rf_addr[3:0]] <= rf_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  smb_word_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .dev_id(DEV),
    .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  // Expected address byte: leading 1, strap, then direction.
  function automatic logic [7:0] id_byte(input logic [5:0] id, input logic rd);
    return 8'h80 + 8'({id, 1'b0}) + 8'(rd);
  endfunction

  function automatic logic [7:0] upper(input logic [15:0] w);
    return 8'(w >> 8);
  endfunction

  function automatic logic [7:0] lower(input logic [15:0] w);
    return 8'(w & 16'h00FF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    b = sda_bus; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] x, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(x[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] x, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      x[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic write_word(input logic [3:0] reg_i, input logic [15:0] w, output logic [3:0] acks);
    logic a;
    bus_start();
    send_byte(id_byte(DEV, 1'b0), a); acks[3] = a;
    send_byte({4'h0, reg_i}, a);      acks[2] = a;
    send_byte(upper(w), a);           acks[1] = a;
    send_byte(lower(w), a);           acks[0] = a;
    bus_stop();
  endtask

  task automatic read_word(input logic [3:0] reg_i, output logic [15:0] w, output logic [2:0] acks);
    logic a;
    logic [7:0] h;
    logic [7:0] l;
    bus_start();
    send_byte(id_byte(DEV, 1'b0), a); acks[2] = a;
    send_byte({4'h0, reg_i}, a);      acks[1] = a;
    bus_rstart();
    send_byte(id_byte(DEV, 1'b1), a); acks[0] = a;
    recv_byte(h, 1'b1);
    recv_byte(l, 1'b0);
    bus_stop();
    w = {h, l};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [3:0] acks4;
    logic [2:0] acks3;
    logic [15:0] w;
    logic [7:0] x;
    int wc;
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 16; i++) begin
      bank[i]  = 16'(i * 16'h0101);
      model[i] = 16'(i * 16'h0101);
    end

    repeat (5) @(negedge clk);
    check("R1 sda_oe in reset", sda_oe, 0);
    check("R1 rf_we in reset", rf_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sda_oe after reset", sda_oe, 0);

    // R2: START right after reset falls inside the lockout.
    bus_start();
    send_byte(id_byte(DEV, 1'b0), a);
    check("R2 addr ack during lockout", a, 0);
    bus_stop();
    repeat (300) @(negedge clk);

    // R4: plain write.
    write_word(4'h3, 16'hA55A, acks4);
    model[3] = 16'hA55A;
    check("R4 four acks", acks4, 4'hF);
    check("R4 bank word", bank[3], 16'hA55A);
    check("R4 one write", wr_cnt, 1);

    // R7: read back with MSB first.
    read_word(4'h3, w, acks3);
    check("R7 read acks", acks3, 3'b111);
    check("R7 read word", w, 16'hA55A);
    read_word(4'h9, w, acks3);
    check("R7 read untouched reg", w, model[9]);

    // R3: leading bit 0 and wrong strap are refused.
    bus_start();
    send_byte(id_byte(DEV, 1'b0) & 8'h7F, a);
    check("R3 msb zero nack", a, 0);
    bus_stop();
    bus_start();
    send_byte(id_byte(DEV ^ 6'h01, 1'b0), a);
    check("R3 wrong strap nack", a, 0);
    send_byte(8'h03, a);
    check("R3 idle after mismatch", a, 0);
    bus_stop();

    // R5: STOP after high byte drops the word.
    wc = wr_cnt;
    bus_start();
    send_byte(id_byte(DEV, 1'b0), a);
    send_byte(8'h05, a);
    send_byte(8'hDE, a);
    bus_stop();
    check("R5 stop mid-word no write", wr_cnt, wc);
    check("R5 stop mid-word reg kept", bank[5], model[5]);

    // R5: repeated START after high byte drops the word, next one lands.
    bus_start();
    send_byte(id_byte(DEV, 1'b0), a);
    send_byte(8'h06, a);
    send_byte(8'h11, a);
    bus_rstart();
    send_byte(id_byte(DEV, 1'b0), a);
    send_byte(8'h07, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop();
    model[7] = 16'h2233;
    check("R5 rstart reg kept", bank[6], model[6]);
    check("R5 rstart second word", bank[7], 16'h2233);

    // R6: third data byte refused.
    wc = wr_cnt;
    bus_start();
    send_byte(id_byte(DEV, 1'b0), a);
    send_byte(8'h08, a);
    send_byte(8'h44, a);
    send_byte(8'h55, a);
    send_byte(8'h66, a);
    check("R6 third byte nack", a, 0);
    bus_stop();
    model[8] = 16'h4455;
    check("R6 single write", wr_cnt, wc + 1);
    check("R6 word kept", bank[8], 16'h4455);

    // R8: master NACKs the high byte; no low byte follows.
    bus_start();
    send_byte(id_byte(DEV, 1'b0), a);
    send_byte(8'h08, a);
    bus_rstart();
    send_byte(id_byte(DEV, 1'b1), a);
    recv_byte(x, 1'b0);
    check("R8 high byte", x, 8'h44);
    recv_byte(x, 1'b0);
    check("R8 no low byte", x, 8'hFF);
    bus_stop();

    // R10: no START after STOP, matching byte not acknowledged.
    send_byte(id_byte(DEV, 1'b0), a);
    check("R10 no ack without start", a, 0);
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();

    // Random traffic, R4/R7/R9 (R9 watched by its assertion).
    for (int k = 0; k < 30; k++) begin
      logic [3:0] r;
      logic [15:0] d;
      r = 4'($urandom_range(0, 15));
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        write_word(r, d, acks4);
        model[r] = d;
        check("R4 random acks", acks4, 4'hF);
        check("R4 random word", bank[r], d);
      end else begin
        read_word(r, w, acks3);
        check("R7 random read", w, model[r]);
      end
    end
    // Corner words: all ones and all zeros.
    write_word(4'hF, 16'hFFFF, acks4);
    read_word(4'hF, w, acks3);
    check("R7 all ones", w, 16'hFFFF);
    write_word(4'h0, 16'h0000, acks4);
    read_word(4'h0, w, acks3);
    check("R7 all zeros", w, 16'h0000);
    check("R9 released at end", sda_oe, 0);

    summary();
    $finish;
  end

endmodule